// File: doc/BRIEF.md
# Compare-and-Branch Condition Unit

This unit decides whether a compare-and-jump instruction is taken. It receives the value of the first source register, a second operand and the 4-bit condition field. In the instruction word that field sits directly after the 8-bit opcode. The second operand comes either from a second register or from a 4-bit immediate that the unit widens to 32 bits. The unit then returns one taken flag. It also raises an invalid-condition flag for any condition code it does not define. Target address generation and the instruction-pointer update happen elsewhere.

Seven condition codes are defined:

- An unconditional code.
- Equality and inequality.
- Greater-than and greater-or-equal, each in an unsigned and a signed form.

There are no less-than codes. The assembler obtains them by swapping the operands.

A parameter selects whether the outputs are registered with one cycle of latency, which is the default, or driven straight from the inputs. The registered flags are cleared by a synchronous active-high reset.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `taken` and `cond_bad` are 0 after that edge (registered build).
- R2: In the registered build, `taken` and `cond_bad` change only at a rising edge and reflect the inputs sampled at that edge.
- R3: Condition code 0 gives `taken` = 1 for any operand values.
- R4: Code 1 is taken when operand A equals operand B. Code 2 is taken when they differ.
- R5: Code 3 is taken when A > B as unsigned 32-bit numbers. Code 4 is taken when A >= B unsigned.
- R6: Code 5 is taken when A > B as two's-complement numbers. Code 6 is taken when A >= B signed.
- R7: With `imm_sel` = 0, operand B is `rs2_val`. With `imm_sel` = 1, operand B is the widened `imm_val`, and `rs2_val` has no effect on the outputs.
- R8: The immediate is zero-extended for codes 3 and 4, and sign-extended from bit 3 for codes 1, 2, 5 and 6.
- R9: Codes 7 to 15 give `taken` = 0 and `cond_bad` = 1. Codes 0 to 6 give `cond_bad` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output |
| rst | input | 1 | Synchronous active-high reset |
| imm_sel | input | 1 | 1 selects the immediate as operand B, 0 selects rs2_val |
| cond_code | input | 4 | Condition field of the instruction |
| rs1_val | input | 32 | Operand A |
| rs2_val | input | 32 | Register operand B |
| imm_val | input | 4 | Immediate operand B before widening |
| taken | output | 1 | Branch decision |
| cond_bad | output | 1 | Undefined condition code seen |

## Verification
On every cycle, the assertions check four things:

- The invalid flag never coexists with a taken decision.
- Code 0 is always taken.
- The invalid flag follows the code range.
- Register-form equality agrees with operand A and operand B.

They also check that reset clears both flags. These checks are made against inputs delayed by the output latency.

The signed versus unsigned orderings, the extension of the immediate and the rule that `rs2_val` is ignored are shown only by the bench's operand patterns. Those patterns sit at the sign boundary, at equal values and at immediate values with bit 3 set.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned COND_W = 4;
    localparam int unsigned IMM_W  = 4;

    typedef enum logic [COND_W-1:0] {
        CND_ALWAYS = 4'd0,
        CND_EQ     = 4'd1,
        CND_NE     = 4'd2,
        CND_UGT    = 4'd3,
        CND_UGE    = 4'd4,
        CND_SGT    = 4'd5,
        CND_SGE    = 4'd6
    } cond_e;

    localparam logic [COND_W-1:0] CND_LAST = 4'd6;

    typedef struct packed {
        logic eq;
        logic ugt;
        logic sgt;
    } cmp_flags_t;

    typedef struct packed {
        logic taken;
        logic bad;
    } decision_t;

    function automatic logic code_defined(input logic [COND_W-1:0] c);
        return c <= CND_LAST;
    endfunction

    function automatic logic code_unsigned(input logic [COND_W-1:0] c);
        return (c == CND_UGT) || (c == CND_UGE);
    endfunction

endpackage

// File: rtl/bcu_operand_sel.sv
module bcu_operand_sel #(
    parameter int unsigned WORD_W = bcu_pkg::WORD_W,
    parameter int unsigned IMM_W  = bcu_pkg::IMM_W
) (
    input  logic              imm_sel,
    input  logic              zero_ext,
    input  logic [WORD_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [WORD_W-1:0] opnd_b
);
    localparam int unsigned PAD_W = WORD_W - IMM_W;

    logic [WORD_W-1:0] imm_wide;

    always_comb begin
        if (zero_ext) begin
            imm_wide = {{PAD_W{1'b0}}, imm};
        end else begin
            imm_wide = {{PAD_W{imm[IMM_W-1]}}, imm};
        end
        opnd_b = imm_sel ? imm_wide : reg_b;
    end
endmodule

// File: rtl/bcu_compare.sv
module bcu_compare #(
    parameter int unsigned WORD_W = bcu_pkg::WORD_W
) (
    input  logic [WORD_W-1:0]  opnd_a,
    input  logic [WORD_W-1:0]  opnd_b,
    output bcu_pkg::cmp_flags_t flags
);
    // Signed ordering obtained by flipping the sign bits and reusing an unsigned compare
    logic [WORD_W-1:0] a_bias;
    logic [WORD_W-1:0] b_bias;

    always_comb begin
        a_bias    = {~opnd_a[WORD_W-1], opnd_a[WORD_W-2:0]};
        b_bias    = {~opnd_b[WORD_W-1], opnd_b[WORD_W-2:0]};
        flags.eq  = (opnd_a == opnd_b);
        flags.ugt = (opnd_a > opnd_b);
        flags.sgt = (a_bias > b_bias);
    end
endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
    import bcu_pkg::*;
#(
    parameter int unsigned COND_W = bcu_pkg::COND_W
) (
    input  logic [COND_W-1:0] cond,
    input  cmp_flags_t        flags,
    output decision_t         dec
);
    always_comb begin
        dec.bad   = !code_defined(cond);
        dec.taken = 1'b0;
        case (cond)
            CND_ALWAYS: dec.taken = 1'b1;
            CND_EQ:     dec.taken = flags.eq;
            CND_NE:     dec.taken = !flags.eq;
            CND_UGT:    dec.taken = flags.ugt;
            CND_UGE:    dec.taken = flags.ugt || flags.eq;
            CND_SGT:    dec.taken = flags.sgt;
            CND_SGE:    dec.taken = flags.sgt || flags.eq;
            default:    dec.taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcu_pkg::*;
#(
    parameter int unsigned WORD_W  = bcu_pkg::WORD_W,
    parameter int unsigned IMM_W   = bcu_pkg::IMM_W,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              imm_sel,
    input  logic [3:0]        cond_code,
    input  logic [WORD_W-1:0] rs1_val,
    input  logic [WORD_W-1:0] rs2_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic              taken,
    output logic              cond_bad
);
    logic [WORD_W-1:0] opnd_b;
    cmp_flags_t        flags;
    decision_t         dec_now;

    bcu_operand_sel #(.WORD_W(WORD_W), .IMM_W(IMM_W)) i_opsel (
        .imm_sel  (imm_sel),
        .zero_ext (code_unsigned(cond_code)),
        .reg_b    (rs2_val),
        .imm      (imm_val),
        .opnd_b   (opnd_b)
    );

    bcu_compare #(.WORD_W(WORD_W)) i_cmp (
        .opnd_a (rs1_val),
        .opnd_b (opnd_b),
        .flags  (flags)
    );

    bcu_cond_eval #(.COND_W(4)) i_eval (
        .cond  (cond_code),
        .flags (flags),
        .dec   (dec_now)
    );

    generate
        if (REG_OUT) begin : g_reg
            decision_t dec_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    dec_q <= '0;
                end else begin
                    dec_q <= dec_now;
                end
            end
            assign taken    = dec_q.taken;
            assign cond_bad = dec_q.bad;
        end else begin : g_comb
            assign taken    = dec_now.taken;
            assign cond_bad = dec_now.bad;
        end
    endgenerate
endmodule

// File: rtl/bcu_branch_chk.sv
module bcu_branch_chk #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned IMM_W   = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              imm_sel,
    input logic [3:0]        cond_code,
    input logic [WORD_W-1:0] rs1_val,
    input logic [WORD_W-1:0] rs2_val,
    input logic [IMM_W-1:0]  imm_val,
    input logic              taken,
    input logic              cond_bad
);
    logic              d_ok;
    logic              d_sel;
    logic [3:0]        d_cond;
    logic [WORD_W-1:0] d_a;
    logic [WORD_W-1:0] d_b;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_ok   <= 1'b0;
                    d_sel  <= 1'b0;
                    d_cond <= '0;
                    d_a    <= '0;
                    d_b    <= '0;
                end else begin
                    d_ok   <= 1'b1;
                    d_sel  <= imm_sel;
                    d_cond <= cond_code;
                    d_a    <= rs1_val;
                    d_b    <= rs2_val;
                end
            end

            // R1
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (!taken && !cond_bad));
        end else begin : g_now
            assign d_ok   = !rst;
            assign d_sel  = imm_sel;
            assign d_cond = cond_code;
            assign d_a    = rs1_val;
            assign d_b    = rs2_val;
        end
    endgenerate

    // R9
    bad_never_taken_chk: assert property (@(posedge clk) disable iff (rst)
        cond_bad |-> !taken);

    // R3
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (d_ok && d_cond == 4'd0) |-> taken);

    // R9
    bad_range_chk: assert property (@(posedge clk) disable iff (rst)
        d_ok |-> (cond_bad == (d_cond > 4'd6)));

    // R4
    eq_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (d_ok && !d_sel && d_cond == 4'd1) |-> (taken == (d_a == d_b)));

    // R4
    ne_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (d_ok && !d_sel && d_cond == 4'd2) |-> (taken == (d_a != d_b)));
endmodule

bind branch_cond_unit bcu_branch_chk #(
    .WORD_W  (WORD_W),
    .IMM_W   (IMM_W),
    .REG_OUT (REG_OUT)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .imm_sel   (imm_sel),
    .cond_code (cond_code),
    .rs1_val   (rs1_val),
    .rs2_val   (rs2_val),
    .imm_val   (imm_val),
    .taken     (taken),
    .cond_bad  (cond_bad)
);

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 22;
    localparam int  WATCHDOG   = 5000;

    // {imm_sel, cond, rs1, rs2, imm, exp_taken, exp_bad}
    localparam logic [74:0] VEC [NVEC] = '{
        {1'b0, 4'd0,  32'h0000_0000, 32'h0000_0005, 4'h0, 1'b1, 1'b0}, // R3 always
        {1'b0, 4'd1,  32'h0000_0007, 32'h0000_0007, 4'h0, 1'b1, 1'b0}, // R4 equal
        {1'b0, 4'd1,  32'h0000_0007, 32'h0000_0008, 4'h0, 1'b0, 1'b0}, // R4 not equal
        {1'b0, 4'd2,  32'h0000_0007, 32'h0000_0008, 4'h0, 1'b1, 1'b0}, // R4 differ
        {1'b0, 4'd2,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0, 1'b0, 1'b0}, // R4 same
        {1'b0, 4'd3,  32'h8000_0000, 32'h0000_0001, 4'h0, 1'b1, 1'b0}, // R5 ugt msb
        {1'b0, 4'd5,  32'h8000_0000, 32'h0000_0001, 4'h0, 1'b0, 1'b0}, // R6 sgt negative
        {1'b0, 4'd4,  32'h0000_0005, 32'h0000_0005, 4'h0, 1'b1, 1'b0}, // R5 uge equal
        {1'b0, 4'd3,  32'h0000_0005, 32'h0000_0005, 4'h0, 1'b0, 1'b0}, // R5 ugt equal
        {1'b0, 4'd6,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b0}, // R6 sge equal
        {1'b0, 4'd6,  32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'h0, 1'b0, 1'b0}, // R6 -2 >= -1
        {1'b0, 4'd5,  32'h0000_0001, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b0}, // R6 1 > -1
        {1'b1, 4'd1,  32'hFFFF_FFFF, 32'h0000_0000, 4'hF, 1'b1, 1'b0}, // R8 sext eq
        {1'b1, 4'd3,  32'h0000_000E, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0}, // R8 zext ugt
        {1'b1, 4'd4,  32'h0000_000F, 32'h0000_0000, 4'hF, 1'b1, 1'b0}, // R8 zext uge
        {1'b1, 4'd5,  32'h0000_0000, 32'h0000_0000, 4'hF, 1'b1, 1'b0}, // R8 sext sgt
        {1'b1, 4'd1,  32'h0000_0003, 32'h0000_0003, 4'h4, 1'b0, 1'b0}, // R7 rs2 ignored
        {1'b0, 4'd1,  32'h0000_0003, 32'h0000_0003, 4'h4, 1'b1, 1'b0}, // R7 rs2 used
        {1'b0, 4'd7,  32'h0000_0000, 32'h0000_0000, 4'h0, 1'b0, 1'b1}, // R9 code 7
        {1'b0, 4'd15, 32'h0000_0000, 32'h0000_0000, 4'h0, 1'b0, 1'b1}, // R9 code 15
        {1'b1, 4'd2,  32'h0000_0008, 32'h0000_0008, 4'h8, 1'b1, 1'b0}, // R8 sext ne
        {1'b0, 4'd6,  32'h7FFF_FFFF, 32'h8000_0000, 4'h0, 1'b1, 1'b0}  // R6 max >= min
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imm_sel = 1'b0;
    logic [3:0]  cond_code = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [3:0]  imm_val = '0;
    logic        taken;
    logic        cond_bad;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_cond_unit i_branch_cond_unit (
        .clk       (clk),
        .rst       (rst),
        .imm_sel   (imm_sel),
        .cond_code (cond_code),
        .rs1_val   (rs1_val),
        .rs2_val   (rs2_val),
        .imm_val   (imm_val),
        .taken     (taken),
        .cond_bad  (cond_bad)
    );

    task automatic check2(input string req, input logic t_exp, input logic b_exp);
        checks++;
        if (taken !== t_exp || cond_bad !== b_exp) begin
            errors++;
            $display("FAIL %s: taken=%b cond_bad=%b expected taken=%b cond_bad=%b",
                     req, taken, cond_bad, t_exp, b_exp);
        end
    endtask

    task automatic apply(input logic s, input logic [3:0] c, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] im);
        @(negedge clk);
        imm_sel   = s;
        cond_code = c;
        rs1_val   = a;
        rs2_val   = b;
        imm_val   = im;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check2("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [74:0] v;
            v = VEC[i];
            apply(v[74], v[73:70], v[69:38], v[37:6], v[5:2]);
            check2($sformatf("vector %0d", i), v[1], v[0]);
        end

        // R7: rs2_val changes alone have no effect with immediate form
        apply(1'b1, 4'd1, 32'h0000_0005, 32'h0000_0000, 4'h5);
        check2("R7", 1'b1, 1'b0);
        apply(1'b1, 4'd1, 32'h0000_0005, 32'hDEAD_BEEF, 4'h5);
        check2("R7", 1'b1, 1'b0);

        // R2: output holds until the edge
        apply(1'b0, 4'd9, 32'h0, 32'h0, 4'h0);
        check2("R9", 1'b0, 1'b1);
        @(negedge clk);
        cond_code = 4'd0;
        #1;
        check2("R2", 1'b0, 1'b1);
        @(posedge clk);
        #1;
        check2("R2", 1'b1, 1'b0);

        // R1: reset clears a taken output
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check2("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check2("R3", 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule